// File: doc/BRIEF.md
# Dual-Mode Timer With Snapshot Capture

A register-programmed counter block with two halves. With the configuration register holding 4, the halves run as two separate timers, each a 24-bit count whose upper 8 bits come from a prescaler byte and whose lower 16 bits come from an interval register. With any other configuration value, one 32-bit counter runs from the first half's interval register, under the first half's enable, mode and status bits. The prescaler plays no part in that case.

Each timer counts up or down, in one-shot or periodic fashion. It can be armed so that it waits for the external trigger input before it starts. A snapshot option in periodic operation latches the count at each timeout into a readback register, while the free-running count stays readable, so software can measure how long it took to respond. Every timeout sets a sticky status bit and emits a one-cycle trigger pulse. A mask gates the status bits onto a single interrupt line.

Software reaches the block through a plain write/read port. Writes take effect at the clock edge. Read data appears on the cycle after the read strobe and is held until the next read.

Top module: `dual_timer`

## Requirements
- R1: After reset, every register, the read data, both trigger pulses and the interrupt line are 0.
- R2: When configuration (address 0, bits 2:0) equals 4, the two halves count independently. Each half counts a 24-bit value: prescale byte (address 6 for the first half, 7 for the second) above the 16-bit interval (address 4, 5). The free counts read back at addresses 13 and 14 (low 16 bits). Address 15 packs the upper bytes: bits 7:0 are the first half's free count, 15:8 the second half's free count, 23:16 the first half's snapshot, 31:24 the second half's snapshot.
- R3: With any other configuration value, a single 32-bit counter uses address 4, control bit 0, the first mode register, status bit 0 and the first trigger output. Address 15 then reads 0.
- R4: Down counting (mode bit 2 clear): enabling loads the start value (the combined interval). The count falls by one each cycle, times out at 0 and reloads the start value on the next cycle.
- R5: Up counting (mode bit 2 set): enabling loads 0. The count rises by one each cycle, times out at the combined interval and reloads 0.
- R6: When mode bits 1:0 are anything but 2 (one-shot), a timeout reloads the count and stops it, and the hardware clears the half's enable bit (address 3, bit 0 or 1).
- R7: With mode bits 1:0 equal to 2 (periodic), counting continues after a timeout, so an interval of N gives a timeout every N+1 cycles.
- R8: With mode bit 3 set, enabling only arms the half. The count holds its start value until trig_i is sampled high, and it moves on the following cycle.
- R9: In periodic operation with mode bit 4 set, each timeout copies the count at timeout into the snapshot readback (address 11 and 12, or the 32-bit value at address 11 when chained).
- R10: In one-shot operation the snapshot readback is never updated, even with mode bit 4 set.
- R11: Each timeout sets that half's status bit (address 8, bit 0 or 1) and pulses its trigger output high for the cycle after the timeout edge. The status bit stays set.
- R12: Writing ones to address 9 clears the matching status bits. irq_o is high exactly when a status bit and its mask bit (address 10) are both set.
- R13: rd_data takes the addressed register value one cycle after rd_en and otherwise holds. Mode registers keep 5 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| trig_i | input | 1 | Start trigger for armed halves |
| trig_a_o | output | 1 | Timeout pulse, first half or chained counter |
| trig_b_o | output | 1 | Timeout pulse, second half |
| irq_o | output | 1 | Masked timeout interrupt |

## Verification
The counting core is run with a short periodic down interval, which confirms the reload period by counting pulses over a whole number of periods. It is then run with a prescale byte set, which separates a 24-bit count from a plain 16-bit one, because the low half wraps without a timeout. An up-count sequence shows the reload target moving from 0 to the interval. A chained 32-bit load whose low bits cross a 24-bit boundary shows the halves really joined. Armed starts held against a late trigger, and one-shot runs with the snapshot bit set, separate the wait, stop and no-capture paths from plain periodic counting. A behavioural model compares every output on every cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int ADDR_W = 4;

  typedef enum logic [3:0] {
    ADDR_CFG    = 4'd0,
    ADDR_MODE_A = 4'd1,
    ADDR_MODE_B = 4'd2,
    ADDR_CTRL   = 4'd3,
    ADDR_LOAD_A = 4'd4,
    ADDR_LOAD_B = 4'd5,
    ADDR_PRE_A  = 4'd6,
    ADDR_PRE_B  = 4'd7,
    ADDR_RIS    = 4'd8,
    ADDR_ICR    = 4'd9,
    ADDR_MASK   = 4'd10,
    ADDR_SNAP_A = 4'd11,
    ADDR_SNAP_B = 4'd12,
    ADDR_FREE_A = 4'd13,
    ADDR_FREE_B = 4'd14,
    ADDR_PRE_RD = 4'd15
  } reg_addr_e;

  localparam logic [2:0] CFG_SPLIT     = 3'd4;
  localparam logic [1:0] KIND_PERIODIC = 2'd2;

  typedef struct packed {
    logic       snap;
    logic       wait_trig;
    logic       up;
    logic [1:0] kind;
  } mode_t;

endpackage

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         start,
  input  logic         up,
  input  logic         periodic,
  input  logic         wait_trig,
  input  logic         snap_en,
  input  logic [W-1:0] limit,
  input  logic         trig,
  output logic         tout,
  output logic         done,
  output logic [W-1:0] val,
  output logic [W-1:0] snap
);

  logic         run_q;
  logic [W-1:0] val_q, snap_q;
  logic [W-1:0] reload, target;

  assign reload = up ? '0 : limit;
  assign target = up ? limit : '0;
  assign tout   = en && run_q && !start && (val_q == target);
  assign done   = tout && !periodic;
  assign val    = val_q;
  assign snap   = snap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      val_q  <= '0;
      snap_q <= '0;
    end else if (start) begin
      val_q <= reload;
      run_q <= !wait_trig;
    end else if (!en) begin
      run_q <= 1'b0;
    end else if (!run_q) begin
      if (wait_trig && trig) run_q <= 1'b1;
    end else if (tout) begin
      val_q <= reload;
      if (periodic && snap_en) snap_q <= val_q;
      if (!periodic) run_q <= 1'b0;
    end else begin
      val_q <= up ? val_q + W'(1) : val_q - W'(1);
    end
  end

  // R4
  down_step_chk: assert property (@(posedge clk) disable iff (rst)
    (en && run_q && !start && !up && !tout) |=> (val_q == $past(val_q) - W'(1)));

  // R5
  up_step_chk: assert property (@(posedge clk) disable iff (rst)
    (en && run_q && !start && up && !tout) |=> (val_q == $past(val_q) + W'(1)));

  // R8
  armed_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !run_q && !start) |=> $stable(val_q));

  // R10
  no_snap_oneshot_chk: assert property (@(posedge clk) disable iff (rst)
    !periodic |=> $stable(snap_q));

  // R6
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !run_q);

endmodule

// File: rtl/dual_timer.sv
module dual_timer #(
  parameter  int HALF_W  = 16,
  parameter  int PRE_W   = 8,
  localparam int DATA_W  = 2 * HALF_W,
  localparam int SPLIT_W = HALF_W + PRE_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic                       rd_en,
  input  logic [tmr_pkg::ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]          wr_data,
  output logic [DATA_W-1:0]          rd_data,
  input  logic                       trig_i,
  output logic                       trig_a_o,
  output logic                       trig_b_o,
  output logic                       irq_o
);
  import tmr_pkg::*;

  logic [2:0]        cfg_q;
  mode_t             mode_q [2];
  logic [1:0]        ctrl_q, ris_q, mask_q;
  logic [DATA_W-1:0] load_a_q;
  logic [HALF_W-1:0] load_b_q;
  logic [PRE_W-1:0]  pre_q [2];

  logic       split, ctrl_wr, icr_wr;
  logic [1:0] start_raw, tout_h, done_h;

  assign split     = (cfg_q == CFG_SPLIT);
  assign ctrl_wr   = wr_en && (reg_addr_e'(addr) == ADDR_CTRL);
  assign icr_wr    = wr_en && (reg_addr_e'(addr) == ADDR_ICR);
  assign start_raw = {2{ctrl_wr}} & wr_data[1:0] & ~ctrl_q;

  // split halves
  logic [SPLIT_W-1:0] val_s [2];
  logic [SPLIT_W-1:0] snap_s [2];
  logic [SPLIT_W-1:0] lim_s [2];
  logic [1:0]         tout_s, done_s;

  assign lim_s[0] = {pre_q[0], load_a_q[HALF_W-1:0]};
  assign lim_s[1] = {pre_q[1], load_b_q};

  for (genvar h = 0; h < 2; h++) begin : g_half
    tmr_core #(.W(SPLIT_W)) u_core (
      .clk       (clk),
      .rst       (rst),
      .en        (ctrl_q[h] && split),
      .start     (start_raw[h] && split),
      .up        (mode_q[h].up),
      .periodic  (mode_q[h].kind == KIND_PERIODIC),
      .wait_trig (mode_q[h].wait_trig),
      .snap_en   (mode_q[h].snap),
      .limit     (lim_s[h]),
      .trig      (trig_i),
      .tout      (tout_s[h]),
      .done      (done_s[h]),
      .val       (val_s[h]),
      .snap      (snap_s[h])
    );
  end

  // chained counter
  logic              tout_w, done_w;
  logic [DATA_W-1:0] val_w, snap_w;

  tmr_core #(.W(DATA_W)) u_wide (
    .clk       (clk),
    .rst       (rst),
    .en        (ctrl_q[0] && !split),
    .start     (start_raw[0] && !split),
    .up        (mode_q[0].up),
    .periodic  (mode_q[0].kind == KIND_PERIODIC),
    .wait_trig (mode_q[0].wait_trig),
    .snap_en   (mode_q[0].snap),
    .limit     (load_a_q),
    .trig      (trig_i),
    .tout      (tout_w),
    .done      (done_w),
    .val       (val_w),
    .snap      (snap_w)
  );

  assign tout_h = split ? tout_s : {1'b0, tout_w};
  assign done_h = split ? done_s : {1'b0, done_w};

  // read mux
  logic [DATA_W-1:0] rd_n;
  always_comb begin
    rd_n = '0;
    case (reg_addr_e'(addr))
      ADDR_CFG:    rd_n = DATA_W'(cfg_q);
      ADDR_MODE_A: rd_n = DATA_W'(mode_q[0]);
      ADDR_MODE_B: rd_n = DATA_W'(mode_q[1]);
      ADDR_CTRL:   rd_n = DATA_W'(ctrl_q);
      ADDR_LOAD_A: rd_n = load_a_q;
      ADDR_LOAD_B: rd_n = DATA_W'(load_b_q);
      ADDR_PRE_A:  rd_n = DATA_W'(pre_q[0]);
      ADDR_PRE_B:  rd_n = DATA_W'(pre_q[1]);
      ADDR_RIS:    rd_n = DATA_W'(ris_q);
      ADDR_ICR:    rd_n = '0;
      ADDR_MASK:   rd_n = DATA_W'(mask_q);
      ADDR_SNAP_A: rd_n = split ? DATA_W'(snap_s[0][HALF_W-1:0]) : snap_w;
      ADDR_SNAP_B: rd_n = split ? DATA_W'(snap_s[1][HALF_W-1:0]) : '0;
      ADDR_FREE_A: rd_n = split ? DATA_W'(val_s[0][HALF_W-1:0]) : val_w;
      ADDR_FREE_B: rd_n = split ? DATA_W'(val_s[1][HALF_W-1:0]) : '0;
      ADDR_PRE_RD: rd_n = split ? DATA_W'({snap_s[1][SPLIT_W-1:HALF_W],
                                           snap_s[0][SPLIT_W-1:HALF_W],
                                           val_s[1][SPLIT_W-1:HALF_W],
                                           val_s[0][SPLIT_W-1:HALF_W]}) : '0;
      default:     rd_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q    <= '0;
      mode_q[0] <= '0;
      mode_q[1] <= '0;
      ctrl_q   <= '0;
      ris_q    <= '0;
      mask_q   <= '0;
      load_a_q <= '0;
      load_b_q <= '0;
      pre_q[0] <= '0;
      pre_q[1] <= '0;
      rd_data  <= '0;
      trig_a_o <= 1'b0;
      trig_b_o <= 1'b0;
    end else begin
      trig_a_o <= tout_h[0];
      trig_b_o <= tout_h[1];
      ris_q    <= (ris_q & ~(icr_wr ? wr_data[1:0] : 2'b00)) | tout_h;
      ctrl_q   <= ctrl_wr ? wr_data[1:0] : (ctrl_q & ~done_h);
      if (wr_en) begin
        case (reg_addr_e'(addr))
          ADDR_CFG:    cfg_q     <= wr_data[2:0];
          ADDR_MODE_A: mode_q[0] <= mode_t'(wr_data[4:0]);
          ADDR_MODE_B: mode_q[1] <= mode_t'(wr_data[4:0]);
          ADDR_LOAD_A: load_a_q  <= wr_data;
          ADDR_LOAD_B: load_b_q  <= wr_data[HALF_W-1:0];
          ADDR_PRE_A:  pre_q[0]  <= wr_data[PRE_W-1:0];
          ADDR_PRE_B:  pre_q[1]  <= wr_data[PRE_W-1:0];
          ADDR_MASK:   mask_q    <= wr_data[1:0];
          default: ;
        endcase
      end
      if (rd_en) rd_data <= rd_n;
    end
  end

  assign irq_o = |(ris_q & mask_q);

  // R11
  trig_sets_status_chk: assert property (@(posedge clk) disable iff (rst)
    trig_a_o |-> ris_q[0]);

  // R11
  trig_b_status_chk: assert property (@(posedge clk) disable iff (rst)
    trig_b_o |-> ris_q[1]);

  // R12
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (ris_q == 2'b00) |-> !irq_o);

  // R6
  enable_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (done_h[0] && !ctrl_wr) |=> !ctrl_q[0]);

  // R3
  chained_b_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !split |-> !tout_h[1]);

endmodule

// File: tb/dual_timer_tb_top.sv
module dual_timer_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0, trig_i = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        trig_a_o, trig_b_o, irq_o;

  int checks = 0;
  int errors = 0;
  bit started = 1'b0;

  always #5 clk = ~clk;

  dual_timer dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .trig_i(trig_i),
    .trig_a_o(trig_a_o), .trig_b_o(trig_b_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  bit [2:0]  m_cfg;
  bit [4:0]  m_mode [2];
  bit [1:0]  m_ctrl, m_ris, m_mask;
  longint    m_load [2];
  longint    m_pre [2];
  longint    m_val [3];
  longint    m_snap [3];
  bit        m_run [3];
  bit        m_trig_a, m_trig_b;
  bit [31:0] m_rd;

  function automatic bit [31:0] m_read(input bit [3:0] a);
    bit sp;
    sp = (m_cfg == 3'd4);
    case (a)
      4'd0:  return 32'(m_cfg);
      4'd1:  return 32'(m_mode[0]);
      4'd2:  return 32'(m_mode[1]);
      4'd3:  return 32'(m_ctrl);
      4'd4:  return m_load[0][31:0];
      4'd5:  return m_load[1][31:0];
      4'd6:  return m_pre[0][31:0];
      4'd7:  return m_pre[1][31:0];
      4'd8:  return 32'(m_ris);
      4'd10: return 32'(m_mask);
      4'd11: return sp ? 32'(m_snap[0] % 65536) : m_snap[2][31:0];
      4'd12: return sp ? 32'(m_snap[1] % 65536) : 32'd0;
      4'd13: return sp ? 32'(m_val[0] % 65536) : m_val[2][31:0];
      4'd14: return sp ? 32'(m_val[1] % 65536) : 32'd0;
      4'd15: return sp ? 32'((m_snap[1] / 65536) * 16777216 + (m_snap[0] / 65536) * 65536
                             + (m_val[1] / 65536) * 256 + (m_val[0] / 65536)) : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin : model
    bit sp, act, st, en, up, per, wt, sn;
    bit [1:0] th, dn;
    longint lim, msk;
    int h;
    if (rst) begin
      m_cfg = '0; m_ctrl = '0; m_ris = '0; m_mask = '0; m_rd = '0;
      m_trig_a = 0; m_trig_b = 0;
      for (int i = 0; i < 2; i++) begin m_mode[i] = '0; m_load[i] = 0; m_pre[i] = 0; end
      for (int i = 0; i < 3; i++) begin m_val[i] = 0; m_snap[i] = 0; m_run[i] = 0; end
    end else begin
      sp = (m_cfg == 3'd4);
      if (rd_en) m_rd = m_read(addr);
      th = 2'b00; dn = 2'b00;
      for (int u = 0; u < 3; u++) begin
        h   = (u == 2) ? 0 : u;
        act = sp ? (u < 2) : (u == 2);
        up  = m_mode[h][2];
        per = (m_mode[h][1:0] == 2'd2);
        wt  = m_mode[h][3];
        sn  = m_mode[h][4];
        msk = (u == 2) ? 64'hFFFF_FFFF : 64'hFF_FFFF;
        lim = (u == 2) ? m_load[0] : (m_pre[u] * 65536 + (m_load[u] % 65536));
        st  = act && wr_en && addr == 4'd3 && wr_data[h] && !m_ctrl[h];
        en  = act && m_ctrl[h];
        if (st) begin
          m_val[u] = up ? 0 : lim;
          m_run[u] = !wt;
        end else if (!en) begin
          m_run[u] = 0;
        end else if (!m_run[u]) begin
          if (wt && trig_i) m_run[u] = 1;
        end else if (m_val[u] == (up ? lim : 0)) begin
          th[h] = 1'b1;
          if (!per) dn[h] = 1'b1;
          if (per && sn) m_snap[u] = m_val[u];
          m_val[u] = up ? 0 : lim;
          if (!per) m_run[u] = 0;
        end else begin
          m_val[u] = up ? ((m_val[u] + 1) & msk) : ((m_val[u] - 1) & msk);
        end
      end
      m_trig_a = th[0];
      m_trig_b = th[1];
      m_ris = (m_ris & ~((wr_en && addr == 4'd9) ? wr_data[1:0] : 2'b00)) | th;
      m_ctrl = (wr_en && addr == 4'd3) ? wr_data[1:0] : (m_ctrl & ~dn);
      if (wr_en) begin
        case (addr)
          4'd0:  m_cfg = wr_data[2:0];
          4'd1:  m_mode[0] = wr_data[4:0];
          4'd2:  m_mode[1] = wr_data[4:0];
          4'd4:  m_load[0] = longint'(wr_data);
          4'd5:  m_load[1] = longint'(wr_data[15:0]);
          4'd6:  m_pre[0] = longint'(wr_data[7:0]);
          4'd7:  m_pre[1] = longint'(wr_data[7:0]);
          4'd10: m_mask = wr_data[1:0];
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (started) begin
      chk("R13 rd_data", rd_data, m_rd);
      chk("R11 trig_a", 32'(trig_a_o), 32'(m_trig_a));
      chk("R11 trig_b", 32'(trig_b_o), 32'(m_trig_b));
      chk("R12 irq", 32'(irq_o), 32'(|(m_ris & m_mask)));
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic wr(input bit [3:0] a, input bit [31:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input bit [3:0] a, input bit [31:0] exp, input string tag);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    chk(tag, rd_data, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_trig();
    trig_i = 1'b1;
    @(negedge clk);
    trig_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R13 watchdog: actual running expected finished");
    finish_run();
  end

  initial begin : stim
    int cnt;
    repeat (3) @(negedge clk);
    started = 1'b1;
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq", 32'(irq_o), 0);
    chk("R1 trig", 32'({trig_a_o, trig_b_o}), 0);
    rd(4'd3, 0, "R1 ctrl");
    rd(4'd8, 0, "R1 ris");

    // R4 / R7 split, periodic down, interval 5
    wr(4'd0, 4);
    wr(4'd4, 5);
    wr(4'd1, 2);
    wr(4'd3, 1);
    rd(4'd13, 5, "R4 start value");
    rd(4'd13, 4, "R4 decrement");
    cnt = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (trig_a_o) cnt++;
    end
    chk("R7 pulses per 60 cycles", 32'(cnt), 10);
    rd(4'd8, 1, "R11 sticky status");
    wr(4'd3, 0);
    wr(4'd9, 3);
    rd(4'd8, 0, "R12 w1c clear");

    // R2 prescaler extends count
    wr(4'd4, 2);
    wr(4'd6, 1);
    wr(4'd3, 1);
    rd(4'd15, 1, "R2 prescale byte");
    rd(4'd13, 1, "R2 low count");
    rd(4'd13, 0, "R2 low zero no timeout");
    rd(4'd13, 32'hFFFF, "R2 low wraps");
    chk("R2 no timeout", 32'(trig_a_o), 0);
    wr(4'd3, 0);
    wr(4'd6, 0);

    // R5 up count, interval 4
    wr(4'd1, 6);
    wr(4'd4, 4);
    wr(4'd3, 1);
    rd(4'd13, 0, "R5 starts at zero");
    rd(4'd13, 1, "R5 count");
    rd(4'd13, 2, "R5 count");
    rd(4'd13, 3, "R5 count");
    rd(4'd13, 4, "R5 reaches interval");
    rd(4'd13, 0, "R5 reloads zero");
    wr(4'd3, 0);
    wr(4'd9, 3);

    // R9 periodic snapshot, up, interval 9
    wr(4'd1, 22);
    wr(4'd4, 9);
    wr(4'd3, 1);
    idle(30);
    rd(4'd11, 9, "R9 snapshot");
    wr(4'd3, 0);
    wr(4'd9, 3);

    // R6 / R10 one-shot up with snapshot bit, second half
    wr(4'd2, 21);
    wr(4'd5, 3);
    wr(4'd3, 2);
    idle(10);
    rd(4'd3, 0, "R6 enable cleared");
    rd(4'd14, 0, "R6 stopped");
    rd(4'd12, 0, "R10 no snapshot");
    rd(4'd8, 2, "R11 status half b");

    // R12 mask
    wr(4'd10, 2);
    chk("R12 irq masked on", 32'(irq_o), 1);
    wr(4'd9, 1);
    chk("R12 other bit kept", 32'(irq_o), 1);
    wr(4'd9, 2);
    chk("R12 irq off", 32'(irq_o), 0);
    rd(4'd8, 0, "R12 status cleared");

    // R6 one-shot down
    wr(4'd2, 1);
    wr(4'd3, 2);
    idle(10);
    rd(4'd14, 3, "R6 holds reloaded start");
    rd(4'd3, 0, "R6 enable cleared");
    wr(4'd9, 3);

    // R8 wait for trigger
    wr(4'd1, 9);
    wr(4'd4, 3);
    wr(4'd3, 1);
    idle(5);
    rd(4'd13, 3, "R8 held while armed");
    rd(4'd3, 1, "R8 still enabled");
    pulse_trig();
    rd(4'd13, 3, "R8 first cycle");
    rd(4'd13, 2, "R8 counting");
    idle(10);
    rd(4'd3, 0, "R6 after triggered run");
    wr(4'd9, 3);

    // R3 chained
    wr(4'd0, 0);
    wr(4'd1, 2);
    wr(4'd4, 32'h0100_0001);
    wr(4'd3, 1);
    rd(4'd13, 32'h0100_0001, "R3 wide start");
    rd(4'd13, 32'h0100_0000, "R3 wide count");
    rd(4'd13, 32'h00FF_FFFF, "R3 wide borrow");
    rd(4'd15, 0, "R3 prescale unavailable");
    wr(4'd3, 0);
    wr(4'd1, 5);
    wr(4'd4, 3);
    wr(4'd3, 1);
    idle(10);
    rd(4'd8, 1, "R3 status bit 0");
    rd(4'd3, 0, "R3 one-shot clears enable");

    // R13 mode width and hold
    wr(4'd1, 32'hFF);
    rd(4'd1, 32'h1F, "R13 mode width");
    idle(3);
    chk("R13 hold", rd_data, 32'h1F);

    idle(2);
    finish_run();
  end

endmodule